// File: doc/BRIEF.md
# PCI Address Translation Window Unit

This block is the address lookup core of a PCI host bridge. A bank of outbound windows maps CPU addresses onto PCI bus addresses, and a bank of inbound windows maps addresses issued by PCI bus masters onto local addresses. Each window is described by a page-number base, a page-number translation target, a power-of-two size code and an enable bit. Software programs these through a small 32-bit register port that accepts one access per cycle.

The two translation ports are purely combinational. Each takes an address and returns a translated address and a hit flag in the same cycle. A register write is captured on the clock edge, so every lookup made after that edge uses the new window setting. An inbound address that matches no window passes through unchanged. An outbound address that matches no window reports a miss and drives zero.

Top module: `pci_xlat_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero, the outbound port reports no hit, and the inbound port passes its address through unchanged.
- R2: Outbound window k (k = 0..3) occupies the 32-byte slot at offset 0xC20 + 0x20*k. Its fields are the translation page at +0x00, extended translation at +0x04, base page at +0x08 and attributes at +0x10. Inbound window j (j = 0..2) occupies the slot at 0xDA0 + 0x20*j, with the translation page at +0x00, base page at +0x08, extended base at +0x0C and attributes at +0x10. Every field reads back the last value written to it, and the extended fields are storage only.
- R3: The word at offset 0xE20 is a plain 32-bit storage register that reads back the last value written to it.
- R4: A read of any other offset returns zero. A write to any other offset changes no register and no translation result.
- R5: With attribute bit 31 set, an outbound window with base page B, translation page T and size code S (attribute bits [5:0]) hits every address A with B*4096 <= A < B*4096 + 2^(S+1). For such an address it outputs T*4096 + (A - B*4096). The last byte of the window hits; the first byte above the window misses, and so does the byte just below the base.
- R6: A window whose attribute bit 31 is clear never hits, whatever its other fields hold.
- R7: When several enabled windows of the same direction hit, the one with the lowest index supplies the result.
- R8: When no outbound window hits, the outbound hit flag is 0 and the output address is 0.
- R9: Inbound windows translate by the same rule as R5 and raise the inbound hit flag.
- R10: When no inbound window hits, the inbound hit flag is 0 and the output equals the input address.
- R11: A write to any window field changes the translation result from the cycle after the write.
- R12: A size code of 44 or more makes the window cover every address from its base up to the top of the 44-bit space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset within the 4 KiB region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access, else zero |
| ob_addr_in | input | 44 | CPU address to translate outbound |
| ob_addr_out | output | 44 | Translated PCI address, zero on a miss |
| ob_hit | output | 1 | An enabled outbound window matched |
| ib_addr_in | input | 44 | PCI bus-master address to translate inbound |
| ib_addr_out | output | 44 | Translated local address, or the input on a miss |
| ib_hit | output | 1 | An enabled inbound window matched |

## Verification
The assertions assume that reg_valid, reg_write, reg_addr and reg_wdata are known values once reset is released, that at most one access arrives per cycle, and that accesses are word-aligned whenever they are meant to hit a field. Misaligned offsets are simply treated as undefined. The bench drives every input on the falling edge from a known value, issues each access for exactly one cycle, and sets the lookup addresses only between accesses. As a result, each translation it samples reflects a register state that has fully settled.

// File: rtl/pci_xlat_pkg.sv
// Package: shared constants and types for the PCI address translation unit.
// Assumes the 4 KiB register region is decoded with byte offsets [11:0],
// where offset bits [11:5] pick a 32-byte slot and bits [4:0] pick a field.
package pci_xlat_pkg;

    localparam int REG_W    = 32;   // register data width
    localparam int PAGE_SH  = 12;   // page-number to byte-address shift
    localparam int SZ_W     = 6;    // width of the size code
    localparam int OFS_W    = 12;   // register offset width
    localparam int EN_BIT   = 31;   // attribute enable bit

    // Slot numbers (offset >> 5) of the first window of each bank and of the timer
    localparam logic [6:0] OB_SLOT0   = 7'h61;  // 0xC20
    localparam logic [6:0] IB_SLOT0   = 7'h6D;  // 0xDA0
    localparam logic [6:0] TIMER_SLOT = 7'h71;  // 0xE20

    // Field offsets within a slot
    localparam logic [4:0] FLD_TRANS  = 5'h00;
    localparam logic [4:0] FLD_OB_EXT = 5'h04;
    localparam logic [4:0] FLD_BASE   = 5'h08;
    localparam logic [4:0] FLD_IB_EXT = 5'h0C;
    localparam logic [4:0] FLD_ATTR   = 5'h10;

    // Register contents of one window
    typedef struct packed {
        logic [REG_W-1:0] trans;   // translation page number
        logic [REG_W-1:0] ext;     // extended address storage
        logic [REG_W-1:0] base;    // window base page number
        logic [REG_W-1:0] attr;    // enable + size code
    } win_regs_t;

endpackage

// File: rtl/xlat_regfile.sv
// Module: xlat_regfile
// Holds the outbound and inbound window registers plus one storage word,
// decodes single-cycle register accesses and returns combinational read data.
// Assumes the window banks and the storage word occupy disjoint slots.
module xlat_regfile
    import pci_xlat_pkg::*;
#(
    parameter int NUM_OB = 4,
    parameter int NUM_IB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output win_regs_t        ob_q [NUM_OB],
    output win_regs_t        ib_q [NUM_IB]
);

    logic [6:0]       slot;
    logic [4:0]       fld;
    logic [7:0]       ob_off;
    logic [7:0]       ib_off;
    logic             wr_en;
    logic [NUM_OB-1:0] ob_we;
    logic [NUM_IB-1:0] ib_we;
    logic             tmr_we;
    logic [REG_W-1:0] timer_q;

    // Split the offset into slot and field, and bias the slot by each bank start
    always_comb begin
        slot   = reg_addr[11:5];
        fld    = reg_addr[4:0];
        ob_off = {1'b0, slot} - {1'b0, OB_SLOT0};
        ib_off = {1'b0, slot} - {1'b0, IB_SLOT0};
        wr_en  = reg_valid && reg_write;
        tmr_we = wr_en && (slot == TIMER_SLOT) && (fld == 5'h00);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_OB; gi++) begin : g_ob
            assign ob_we[gi] = wr_en && (ob_off == 8'(gi));

            // Capture a write into one field of outbound window gi
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ob_q[gi] <= '0;
                end else if (ob_we[gi]) begin
                    case (fld)
                        FLD_TRANS:  ob_q[gi].trans <= reg_wdata;
                        FLD_OB_EXT: ob_q[gi].ext   <= reg_wdata;
                        FLD_BASE:   ob_q[gi].base  <= reg_wdata;
                        FLD_ATTR:   ob_q[gi].attr  <= reg_wdata;
                        default:    ;
                    endcase
                end
            end

            // R4: a write that does not target this window leaves it untouched
            assert_ob_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !(slot == OB_SLOT0 + 7'(gi))) |=> $stable(ob_q[gi]));
        end

        for (gi = 0; gi < NUM_IB; gi++) begin : g_ib
            assign ib_we[gi] = wr_en && (ib_off == 8'(gi));

            // Capture a write into one field of inbound window gi
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ib_q[gi] <= '0;
                end else if (ib_we[gi]) begin
                    case (fld)
                        FLD_TRANS:  ib_q[gi].trans <= reg_wdata;
                        FLD_BASE:   ib_q[gi].base  <= reg_wdata;
                        FLD_IB_EXT: ib_q[gi].ext   <= reg_wdata;
                        FLD_ATTR:   ib_q[gi].attr  <= reg_wdata;
                        default:    ;
                    endcase
                end
            end

            // R4: a write that does not target this window leaves it untouched
            assert_ib_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !(slot == IB_SLOT0 + 7'(gi))) |=> $stable(ib_q[gi]));
        end
    endgenerate

    // Plain storage word at the timer offset
    always_ff @(posedge clk) begin
        if (!rst_n)      timer_q <= '0;
        else if (tmr_we) timer_q <= reg_wdata;
    end

    // Select read data for a read access; undefined offsets give zero
    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write) begin
            for (int i = 0; i < NUM_OB; i++) begin
                if (ob_off == 8'(i)) begin
                    case (fld)
                        FLD_TRANS:  reg_rdata = ob_q[i].trans;
                        FLD_OB_EXT: reg_rdata = ob_q[i].ext;
                        FLD_BASE:   reg_rdata = ob_q[i].base;
                        FLD_ATTR:   reg_rdata = ob_q[i].attr;
                        default:    reg_rdata = '0;
                    endcase
                end
            end
            for (int i = 0; i < NUM_IB; i++) begin
                if (ib_off == 8'(i)) begin
                    case (fld)
                        FLD_TRANS:  reg_rdata = ib_q[i].trans;
                        FLD_BASE:   reg_rdata = ib_q[i].base;
                        FLD_IB_EXT: reg_rdata = ib_q[i].ext;
                        FLD_ATTR:   reg_rdata = ib_q[i].attr;
                        default:    reg_rdata = '0;
                    endcase
                end
            end
            if (slot == TIMER_SLOT && fld == 5'h00) reg_rdata = timer_q;
        end
    end

    // R3: a write to the storage word is seen in the next read of it
    assert_timer_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> (timer_q == $past(reg_wdata)));

    // R4: reads below the control area return zero
    assert_low_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_addr[11:10] != 2'b11) |-> (reg_rdata == '0));

    // R4: the read strobe gates the data bus
    assert_idle_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_valid |-> (reg_rdata == '0));

endmodule

// File: rtl/xlat_window.sv
// Module: xlat_window
// Combinational match and translation for one window. The base and target
// are page numbers, and the size is 2^(code+1) bytes, saturating at the full
// address space. Assumes the address width equals page bits plus the page shift.
module xlat_window
    import pci_xlat_pkg::*;
#(
    parameter int PG_W = REG_W,
    parameter int SH   = PAGE_SH,
    parameter int SW   = SZ_W,
    localparam int AW  = PG_W + SH
) (
    input  logic          en,
    input  logic [PG_W-1:0] base_pg,
    input  logic [PG_W-1:0] trans_pg,
    input  logic [SW-1:0] size_code,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] xaddr
);

    logic [AW-1:0] base_b;
    logic [AW-1:0] trans_b;
    logic [AW:0]   span;
    logic [AW:0]   limit;

    // Byte addresses of base and target, span and exclusive end of the window
    always_comb begin
        base_b  = {base_pg,  {SH{1'b0}}};
        trans_b = {trans_pg, {SH{1'b0}}};
        if (int'(size_code) >= AW) span = (AW+1)'(1) << AW;
        else                       span = (AW+1)'(2) << size_code;
        limit = {1'b0, base_b} + span;
    end

    // Range compare and offset-preserving translation
    always_comb begin
        hit   = en && (addr >= base_b) && ({1'b0, addr} < limit);
        xaddr = trans_b + (addr - base_b);
    end

endmodule

// File: rtl/xlat_pick.sv
// Module: xlat_pick
// Fixed-priority selector: the lowest-index asserted request wins and its
// candidate value is passed on. With no request the value is zero.
module xlat_pick #(
    parameter int N = 4,
    parameter int W = 44
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] cand [N],
    output logic         any,
    output logic [N-1:0] grant,
    output logic [W-1:0] sel
);

    // Scan from the top so the lowest index is assigned last
    always_comb begin
        any   = 1'b0;
        grant = '0;
        sel   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any   = 1'b1;
                grant = '0;
                grant[i] = 1'b1;
                sel   = cand[i];
            end
        end
    end

endmodule

// File: rtl/pci_xlat_unit.sv
// Module: pci_xlat_unit
// Top of the PCI address translation unit: register file, one matcher per
// window and a lowest-index-wins selector per direction. Lookups are
// combinational on the registered window state. Assumes one register
// access per cycle and window banks that do not overlap the storage word.
module pci_xlat_unit
    import pci_xlat_pkg::*;
#(
    parameter int NUM_OB = 4,
    parameter int NUM_IB = 3,
    localparam int AW    = REG_W + PAGE_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [AW-1:0]    ob_addr_in,
    output logic [AW-1:0]    ob_addr_out,
    output logic             ob_hit,
    input  logic [AW-1:0]    ib_addr_in,
    output logic [AW-1:0]    ib_addr_out,
    output logic             ib_hit
);

    win_regs_t         ob_q [NUM_OB];
    win_regs_t         ib_q [NUM_IB];
    logic [NUM_OB-1:0] ob_hv;
    logic [NUM_IB-1:0] ib_hv;
    logic [AW-1:0]     ob_xa [NUM_OB];
    logic [AW-1:0]     ib_xa [NUM_IB];
    logic [NUM_OB-1:0] ob_grant;
    logic [NUM_IB-1:0] ib_grant;
    logic              ib_any;
    logic [AW-1:0]     ib_sel;

    xlat_regfile #(.NUM_OB(NUM_OB), .NUM_IB(NUM_IB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ob_q      (ob_q),
        .ib_q      (ib_q)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_OB; gi++) begin : g_obw
            xlat_window u_win (
                .en        (ob_q[gi].attr[EN_BIT]),
                .base_pg   (ob_q[gi].base),
                .trans_pg  (ob_q[gi].trans),
                .size_code (ob_q[gi].attr[SZ_W-1:0]),
                .addr      (ob_addr_in),
                .hit       (ob_hv[gi]),
                .xaddr     (ob_xa[gi])
            );

            // R6: a disabled outbound window never reports a match
            assert_ob_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !ob_q[gi].attr[EN_BIT] |-> !ob_hv[gi]);
        end

        for (gi = 0; gi < NUM_IB; gi++) begin : g_ibw
            xlat_window u_win (
                .en        (ib_q[gi].attr[EN_BIT]),
                .base_pg   (ib_q[gi].base),
                .trans_pg  (ib_q[gi].trans),
                .size_code (ib_q[gi].attr[SZ_W-1:0]),
                .addr      (ib_addr_in),
                .hit       (ib_hv[gi]),
                .xaddr     (ib_xa[gi])
            );

            // R6: a disabled inbound window never reports a match
            assert_ib_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !ib_q[gi].attr[EN_BIT] |-> !ib_hv[gi]);
        end
    endgenerate

    xlat_pick #(.N(NUM_OB), .W(AW)) u_ob_pick (
        .req   (ob_hv),
        .cand  (ob_xa),
        .any   (ob_hit),
        .grant (ob_grant),
        .sel   (ob_addr_out)
    );

    xlat_pick #(.N(NUM_IB), .W(AW)) u_ib_pick (
        .req   (ib_hv),
        .cand  (ib_xa),
        .any   (ib_any),
        .grant (ib_grant),
        .sel   (ib_sel)
    );

    // Inbound misses fall back to the untranslated address
    always_comb begin
        ib_hit      = ib_any;
        ib_addr_out = ib_any ? ib_sel : ib_addr_in;
    end

    // R7: at most one window is granted per direction
    assert_ob_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ob_grant));
    assert_ib_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ib_grant));

    // R7: a granted window is one that matched
    assert_ob_grant_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_grant & ~ob_hv) == '0);

    // R8: an outbound miss drives a zero address
    assert_ob_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ob_hit |-> (ob_addr_out == '0));

    // R10: an inbound miss passes the address through
    assert_ib_miss_ident_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ib_hit |-> (ib_addr_out == ib_addr_in));

endmodule

// File: tb/pci_xlat_unit_test.sv
`timescale 1ns/100ps
module pci_xlat_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [43:0] ob_addr_in = '0;
    logic [43:0] ob_addr_out;
    logic        ob_hit;
    logic [43:0] ib_addr_in = '0;
    logic [43:0] ib_addr_out;
    logic        ib_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] EN = 32'h8000_0000;

    always #2.5 clk = ~clk;

    pci_xlat_unit uut (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ob_addr_in(ob_addr_in), .ob_addr_out(ob_addr_out), .ob_hit(ob_hit),
        .ib_addr_in(ib_addr_in), .ib_addr_out(ib_addr_out), .ib_hit(ib_hit)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
        reg_valid = 1'b0; reg_addr = '0;
    endtask

    task automatic ob_look(input string tag, input logic [43:0] a,
                           input logic h, input logic [43:0] exp);
        @(negedge clk);
        ob_addr_in = a;
        #1;
        chk({tag, " hit"}, 64'(ob_hit), 64'(h));
        chk({tag, " addr"}, 64'(ob_addr_out), 64'(exp));
    endtask

    task automatic ib_look(input string tag, input logic [43:0] a,
                           input logic h, input logic [43:0] exp);
        @(negedge clk);
        ib_addr_in = a;
        #1;
        chk({tag, " hit"}, 64'(ib_hit), 64'(h));
        chk({tag, " addr"}, 64'(ib_addr_out), 64'(exp));
    endtask

    // R1: reset state
    task automatic t_reset();
        rd("R1 ob attr", 12'hC30, 32'h0);
        rd("R1 ib base", 12'hDA8, 32'h0);
        rd("R1 timer", 12'hE20, 32'h0);
        ob_look("R1 ob", 44'h0, 1'b0, 44'h0);
        ib_look("R1 ib", 44'h123_4567, 1'b0, 44'h123_4567);
    endtask

    // R2: field placement and read-back
    task automatic t_regmap();
        wr(12'hC60, 32'h1111_0001);
        wr(12'hC64, 32'h2222_0002);
        wr(12'hC68, 32'h3333_0003);
        wr(12'hC70, 32'h0000_000A);
        wr(12'hDC0, 32'h4444_0004);
        wr(12'hDC8, 32'h5555_0005);
        wr(12'hDCC, 32'h6666_0006);
        wr(12'hDD0, 32'h0000_0015);
        rd("R2 ob2 trans", 12'hC60, 32'h1111_0001);
        rd("R2 ob2 ext", 12'hC64, 32'h2222_0002);
        rd("R2 ob2 base", 12'hC68, 32'h3333_0003);
        rd("R2 ob2 attr", 12'hC70, 32'h0000_000A);
        rd("R2 ib1 trans", 12'hDC0, 32'h4444_0004);
        rd("R2 ib1 base", 12'hDC8, 32'h5555_0005);
        rd("R2 ib1 ext", 12'hDCC, 32'h6666_0006);
        rd("R2 ib1 attr", 12'hDD0, 32'h0000_0015);
        rd("R2 ob1 untouched", 12'hC48, 32'h0);
        rd("R2 ib0 untouched", 12'hDA0, 32'h0);
    endtask

    // R3: storage word
    task automatic t_timer();
        wr(12'hE20, 32'hDEAD_BEEF);
        rd("R3 timer", 12'hE20, 32'hDEAD_BEEF);
        wr(12'hE20, 32'h0000_5A5A);
        rd("R3 timer rewrite", 12'hE20, 32'h0000_5A5A);
    endtask

    // R4: undefined offsets
    task automatic t_undef();
        wr(12'hC74, 32'hFFFF_FFFF);
        wr(12'hC00, 32'hFFFF_FFFF);
        wr(12'hD80, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'hE24, 32'hFFFF_FFFF);
        wr(12'hDC4, 32'hFFFF_FFFF);
        rd("R4 rd C74", 12'hC74, 32'h0);
        rd("R4 rd C00", 12'hC00, 32'h0);
        rd("R4 rd D80", 12'hD80, 32'h0);
        rd("R4 rd 004", 12'h004, 32'h0);
        rd("R4 rd E24", 12'hE24, 32'h0);
        rd("R4 ob2 attr kept", 12'hC70, 32'h0000_000A);
        rd("R4 ib1 trans kept", 12'hDC0, 32'h4444_0004);
        rd("R4 timer kept", 12'hE20, 32'h0000_5A5A);
        ob_look("R4 no window", 44'h3333_0003_000, 1'b0, 44'h0);
    endtask

    // R5/R8: basic outbound window, 4 KiB at 0x10000 -> 0x200000
    task automatic t_outbound();
        wr(12'hC20, 32'h0000_0200);
        wr(12'hC28, 32'h0000_0010);
        wr(12'hC30, EN | 32'd11);
        ob_look("R5 first byte", 44'h1_0000, 1'b1, 44'h20_0000);
        ob_look("R5 middle", 44'h1_0ABC, 1'b1, 44'h20_0ABC);
        ob_look("R5 last byte", 44'h1_0FFF, 1'b1, 44'h20_0FFF);
        ob_look("R5 above end", 44'h1_1000, 1'b0, 44'h0);
        ob_look("R8 below base", 44'h0_FFFF, 1'b0, 44'h0);
    endtask

    // R6/R11: disabling takes effect the next cycle
    task automatic t_disable();
        @(negedge clk);
        ob_addr_in = 44'h1_0000;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 12'hC30; reg_wdata = 32'd11;
        #1;
        chk("R11 before edge hit", 64'(ob_hit), 64'd1);
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
        #1;
        chk("R11/R6 after edge hit", 64'(ob_hit), 64'd0);
        chk("R6 disabled addr", 64'(ob_addr_out), 64'd0);
    endtask

    // R7: overlapping windows, lowest index wins
    task automatic t_priority();
        wr(12'hC20, 32'h0000_0300);
        wr(12'hC28, 32'h0000_0020);
        wr(12'hC30, EN | 32'd12);
        wr(12'hC40, 32'h0000_0400);
        wr(12'hC48, 32'h0000_0020);
        wr(12'hC50, EN | 32'd13);
        ob_look("R7 both hit", 44'h2_0010, 1'b1, 44'h30_0010);
        ob_look("R7 only win1", 44'h2_2000, 1'b1, 44'h40_2000);
        wr(12'hC30, 32'd12);
        ob_look("R7 win0 off", 44'h2_0010, 1'b1, 44'h40_0010);
    endtask

    // R9/R10/R11: inbound window 2, 64 KiB at 0x80000 -> 0x5000
    task automatic t_inbound();
        wr(12'hDE0, 32'h0000_0005);
        wr(12'hDE8, 32'h0000_0080);
        wr(12'hDF0, EN | 32'd15);
        ib_look("R9 inside", 44'h8_1234, 1'b1, 44'h6234);
        ib_look("R9 last byte", 44'h8_FFFF, 1'b1, 44'h1_4FFF);
        ib_look("R10 above", 44'h9_0000, 1'b0, 44'h9_0000);
        ib_look("R10 below", 44'h7_FFFF, 1'b0, 44'h7_FFFF);
        wr(12'hDE0, 32'h0000_0100);
        ib_look("R11 new target", 44'h8_1234, 1'b1, 44'h10_1234);
    endtask

    // R12: saturating size code
    task automatic t_saturate();
        wr(12'hC80, 32'h0000_0001);
        wr(12'hC88, 32'h8000_0000);
        wr(12'hC90, EN | 32'd63);
        ob_look("R12 top of space", 44'hFFF_FFFF_FFFF, 1'b1, 44'h800_0000_0FFF);
        ob_look("R12 base", 44'h800_0000_0000, 1'b1, 44'h1000);
        ob_look("R12 below base", 44'h7FF_FFFF_FFFF, 1'b0, 44'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_timer();
        t_undef();
        t_outbound();
        t_disable();
        t_priority();
        t_inbound();
        t_saturate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule